// File: doc/BRIEF.md
# Boundary Write-Protect Register

This block guards a 64-word memory against unwanted writes. It stores one boundary address. When protection is active, every word at that address or above is refused for writing, and every word below it stays writable. The serial command engine passes each protect-register command to the block as a one-cycle strobe carrying the opcode, the six address bits, a select line that routes the command to this block, and the program-enable level. The memory write path presents a candidate address and receives a combinational allow or block answer.

Any command that changes the protection needs the program-enable level high. It must also follow an arming command. Arming covers exactly one such command and is then used up. A seal command freezes the protection for good, and only the power-on reset releases it. That reset stands in for the nonvolatile retention of the real state. A fetch command returns the boundary to the engine, zero-extended to the readback width, one cycle after the strobe.

Top module: `wp_boundary_guard`

## Requirements
- R1: After reset protection is inactive, the block is unarmed and unsealed, and the boundary is 0: every candidate address is allowed and a fetch returns 0.
- R2: `wr_allow` is combinational. It is 1 when protection is inactive or `cand_addr` is below the boundary, and 0 when protection is active and `cand_addr` is greater than or equal to the boundary.
- R3: A load command (`cmd_op`=01, `cmd_prot`=1, `cmd_pe`=1) issued while armed stores `cmd_addr` as the boundary and activates protection from the next cycle.
- R4: An arm command (`cmd_op`=00 with the two top address bits 11, `cmd_prot`=1, `cmd_pe`=1) sets the armed state. Load, erase and seal commands issued while unarmed have no effect.
- R5: The armed state is used up by the first load, erase or seal command that follows. A second such command without a new arm has no effect.
- R6: With `cmd_pe`=0, the arm, load, erase and seal commands all have no effect.
- R7: An erase command (`cmd_op`=11, address all ones, `cmd_prot`=1, `cmd_pe`=1) issued while armed deactivates protection and keeps the stored boundary value.
- R8: A seal command (`cmd_op`=00, address all zeros, `cmd_prot`=1, `cmd_pe`=1) issued while armed freezes the protection. After that, load, erase and seal commands change nothing until reset.
- R9: A fetch command (`cmd_op`=10, `cmd_prot`=1, any `cmd_pe`) raises `rd_valid` for one cycle in the next cycle, with `rd_data` holding the boundary in its low bits and zeros above them.
- R10: Commands with `cmd_prot`=0 have no effect on the protection state.
- R11: Near-miss encodings have no effect and do not use up the armed state. These are opcode 11 with an address other than all ones, and opcode 00 with an address that is neither all zeros nor has 11 in its top two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; also clears the seal |
| cmd_stb | input | 1 | One-cycle command strobe from the serial engine |
| cmd_prot | input | 1 | Routes the command to this block when 1 |
| cmd_pe | input | 1 | Program-enable level qualifying the modifying commands |
| cmd_op | input | 2 | Command opcode |
| cmd_addr | input | ADDR_W (6) | Address field of the command |
| cand_addr | input | ADDR_W (6) | Candidate write address from the memory path |
| wr_allow | output | 1 | 1 when a write to `cand_addr` is permitted |
| rd_valid | output | 1 | Fetch result valid, one cycle |
| rd_data | output | RD_W (16) | Zero-extended boundary for readback |

## Verification
If the internal state is wrong, the fault reaches the ports within one cycle. A bad boundary or active flag flips `wr_allow` for candidates near the boundary as soon as the strobe edge has passed. A fetch then shows the bad boundary on `rd_data` on the following cycle. An armed state that is left stale or cleared too early appears only on the next modifying command. For that reason the sequences pair every load, erase and seal with a probe address on each side of the boundary, and repeat a command without re-arming. A seal that fails to hold is exposed by an erase and a load attempted afterwards, each followed by a fetch.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        OP_CTRL  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_FETCH = 2'b10,
        OP_ERASE = 2'b11
    } wp_op_e;

    typedef struct packed {
        logic fetch;
        logic arm;
        logic load;
        logic erase;
        logic seal;
    } wp_cmd_t;

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              stb,
    input  logic              prot,
    input  logic              pe,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] addr,
    output wp_cmd_t           cmd
);
    localparam logic [ADDR_W-1:0] ALL_ONES  = '1;
    localparam logic [ADDR_W-1:0] ALL_ZEROS = '0;

    logic   hit;
    logic   mod_ok;
    wp_op_e opc;

    assign opc    = wp_op_e'(op);
    assign hit    = stb & prot;
    assign mod_ok = hit & pe;

    always_comb begin
        cmd       = '0;
        cmd.fetch = hit && (opc == OP_FETCH);
        cmd.load  = mod_ok && (opc == OP_LOAD);
        cmd.erase = mod_ok && (opc == OP_ERASE) && (addr == ALL_ONES);
        cmd.arm   = mod_ok && (opc == OP_CTRL) && (addr[ADDR_W-1 -: 2] == 2'b11);
        cmd.seal  = mod_ok && (opc == OP_CTRL) && (addr == ALL_ZEROS);
    end

endmodule

// File: rtl/wp_bound_cmp.sv
module wp_bound_cmp #(
    parameter int ADDR_W = 6
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] boundary,
    input  logic [ADDR_W-1:0] cand,
    output logic              allow
);
    logic below;

    assign below = (cand < boundary);
    assign allow = !active || below;

endmodule

// File: rtl/wp_boundary_guard.sv
module wp_boundary_guard
    import wp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_stb,
    input  logic              cmd_prot,
    input  logic              cmd_pe,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [ADDR_W-1:0] cand_addr,
    output logic              wr_allow,
    output logic              rd_valid,
    output logic [RD_W-1:0]   rd_data
);
    localparam int PAD_W = RD_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] boundary;
        logic              active;
        logic              armed;
        logic              sealed;
        logic              rd_valid;
        logic [RD_W-1:0]   rd_data;
    } state_t;

    state_t  st_d;
    state_t  st_q;
    wp_cmd_t cmd;
    logic    consume;

    logic [ADDR_W-1:0] bound_w;
    logic              active_w;
    logic              armed_w;
    logic              sealed_w;

    wp_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .stb  (cmd_stb),
        .prot (cmd_prot),
        .pe   (cmd_pe),
        .op   (cmd_op),
        .addr (cmd_addr),
        .cmd  (cmd)
    );

    assign consume = st_q.armed && (cmd.load || cmd.erase || cmd.seal);

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        if (cmd.fetch) begin
            st_d.rd_valid = 1'b1;
            st_d.rd_data  = {{PAD_W{1'b0}}, st_q.boundary};
        end
        if (cmd.arm) begin
            st_d.armed = 1'b1;
        end
        if (consume) begin
            st_d.armed = 1'b0;
            if (!st_q.sealed) begin
                if (cmd.load) begin
                    st_d.boundary = cmd_addr;
                    st_d.active   = 1'b1;
                end
                if (cmd.erase) begin
                    st_d.active = 1'b0;
                end
                if (cmd.seal) begin
                    st_d.sealed = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bound_w  = st_q.boundary;
    assign active_w = st_q.active;
    assign armed_w  = st_q.armed;
    assign sealed_w = st_q.sealed;

    wp_bound_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .active   (active_w),
        .boundary (bound_w),
        .cand     (cand_addr),
        .allow    (wr_allow)
    );

    assign rd_valid = st_q.rd_valid;
    assign rd_data  = st_q.rd_data;

endmodule

// File: rtl/wp_boundary_guard_chk.sv
module wp_boundary_guard_chk #(
    parameter int ADDR_W = 6,
    parameter int RD_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_stb,
    input logic              cmd_prot,
    input logic              cmd_pe,
    input logic [1:0]        cmd_op,
    input logic [ADDR_W-1:0] cand_addr,
    input logic              wr_allow,
    input logic              rd_valid,
    input logic [RD_W-1:0]   rd_data,
    input logic [ADDR_W-1:0] bound_w,
    input logic              active_w,
    input logic              armed_w,
    input logic              sealed_w
);
    p_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_w && (cand_addr >= bound_w)) |-> !wr_allow);

    p_unarmed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_w |=> ($stable(bound_w) && $stable(active_w) && $stable(sealed_w)));

    p_no_pe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && !cmd_pe) |=> ($stable(bound_w) && $stable(active_w)
                                  && $stable(sealed_w) && $stable(armed_w)));

    p_seal_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sealed_w |=> (sealed_w && $stable(bound_w) && $stable(active_w)));

    p_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_prot && cmd_op == 2'b10) |=>
            (rd_valid && rd_data[ADDR_W-1:0] == $past(bound_w)));

    p_zero_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[RD_W-1:ADDR_W] == '0));

    p_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_stb || !cmd_prot) |=> ($stable(bound_w) && $stable(active_w)
                                     && $stable(sealed_w) && $stable(armed_w) && !rd_valid));

endmodule

bind wp_boundary_guard wp_boundary_guard_chk #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .cmd_prot  (cmd_prot),
    .cmd_pe    (cmd_pe),
    .cmd_op    (cmd_op),
    .cand_addr (cand_addr),
    .wr_allow  (wr_allow),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .bound_w   (bound_w),
    .active_w  (active_w),
    .armed_w   (armed_w),
    .sealed_w  (sealed_w)
);

// File: tb/wp_boundary_guard_tb.sv
module wp_boundary_guard_tb;
    localparam int ADDR_W = 6;
    localparam int RD_W   = 16;
    localparam int NV     = 26;

    // row: req(4) sel(1) pe(1) op(2) addr(6) cand(6) exp_allow(1) exp_rdv(1) exp_rd(6)
    localparam logic [27:0] VEC [NV] = '{
        {4'd4,  1'b1, 1'b1, 2'b01, 6'd20, 6'd30, 1'b1, 1'b0, 6'd0},  // R4 load while unarmed
        {4'd1,  1'b1, 1'b0, 2'b10, 6'd0,  6'd63, 1'b1, 1'b1, 6'd0},  // R1 fetch after reset
        {4'd6,  1'b1, 1'b0, 2'b00, 6'h30, 6'd30, 1'b1, 1'b0, 6'd0},  // R6 arm with pe low
        {4'd6,  1'b1, 1'b1, 2'b01, 6'd20, 6'd30, 1'b1, 1'b0, 6'd0},  // R6 still unarmed
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd30, 1'b1, 1'b0, 6'd0},  // R4 arm
        {4'd3,  1'b1, 1'b1, 2'b01, 6'd20, 6'd20, 1'b0, 1'b0, 6'd0},  // R3 load 20
        {4'd10, 1'b0, 1'b1, 2'b01, 6'd5,  6'd19, 1'b1, 1'b0, 6'd0},  // R10 deselected
        {4'd9,  1'b1, 1'b1, 2'b10, 6'd0,  6'd63, 1'b0, 1'b1, 6'd20}, // R9 fetch 20
        {4'd5,  1'b1, 1'b1, 2'b01, 6'd5,  6'd10, 1'b1, 1'b0, 6'd0},  // R5 second load ignored
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h3A, 6'd10, 1'b1, 1'b0, 6'd0},  // R4 arm, low bits don't care
        {4'd11, 1'b1, 1'b1, 2'b11, 6'h3E, 6'd25, 1'b0, 1'b0, 6'd0},  // R11 near-miss erase
        {4'd7,  1'b1, 1'b1, 2'b11, 6'h3F, 6'd25, 1'b1, 1'b0, 6'd0},  // R7 erase, arm kept by R11
        {4'd7,  1'b1, 1'b1, 2'b10, 6'd0,  6'd63, 1'b1, 1'b1, 6'd20}, // R7 boundary kept
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd0,  1'b1, 1'b0, 6'd0},  // R4 arm
        {4'd2,  1'b1, 1'b1, 2'b01, 6'd0,  6'd0,  1'b0, 1'b0, 6'd0},  // R2 boundary 0 blocks all
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd0,  1'b0, 1'b0, 6'd0},  // R4 arm
        {4'd2,  1'b1, 1'b1, 2'b01, 6'd63, 6'd62, 1'b1, 1'b0, 6'd0},  // R2 62 below 63
        {4'd2,  1'b0, 1'b0, 2'b00, 6'd0,  6'd63, 1'b0, 1'b0, 6'd0},  // R2 63 blocked
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd63, 1'b0, 1'b0, 6'd0},  // R4 arm
        {4'd11, 1'b1, 1'b1, 2'b00, 6'h01, 6'd63, 1'b0, 1'b0, 6'd0},  // R11 near-miss seal
        {4'd8,  1'b1, 1'b1, 2'b00, 6'h00, 6'd63, 1'b0, 1'b0, 6'd0},  // R8 seal
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd63, 1'b0, 1'b0, 6'd0},  // R4 arm
        {4'd8,  1'b1, 1'b1, 2'b11, 6'h3F, 6'd63, 1'b0, 1'b0, 6'd0},  // R8 erase refused
        {4'd4,  1'b1, 1'b1, 2'b00, 6'h30, 6'd20, 1'b1, 1'b0, 6'd0},  // R4 arm
        {4'd8,  1'b1, 1'b1, 2'b01, 6'd10, 6'd20, 1'b1, 1'b0, 6'd0},  // R8 load refused
        {4'd8,  1'b1, 1'b1, 2'b10, 6'd0,  6'd63, 1'b0, 1'b1, 6'd63}  // R8 boundary frozen
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_stb = 1'b0;
    logic              cmd_prot = 1'b0;
    logic              cmd_pe = 1'b0;
    logic [1:0]        cmd_op = 2'b00;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [ADDR_W-1:0] cand_addr = '0;
    logic              wr_allow;
    logic              rd_valid;
    logic [RD_W-1:0]   rd_data;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    wp_boundary_guard #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb   (cmd_stb),
        .cmd_prot  (cmd_prot),
        .cmd_pe    (cmd_pe),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cand_addr (cand_addr),
        .wr_allow  (wr_allow),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    task automatic check(input string req, input logic [RD_W-1:0] act, input logic [RD_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic sel, input logic pe, input logic [1:0] op,
                         input logic [ADDR_W-1:0] addr);
        cmd_stb  = 1'b1;
        cmd_prot = sel;
        cmd_pe   = pe;
        cmd_op   = op;
        cmd_addr = addr;
        @(posedge clk);
        @(negedge clk);
        cmd_stb  = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        cand_addr = '0;
        #1;
        check("R1 allow in reset", {15'd0, wr_allow}, 16'd1);
        check("R1 rd_valid in reset", {15'd0, rd_valid}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d row %0d", v[27:24], i);
            cand_addr = v[13:8];
            issue(v[23], v[22], v[21:20], v[19:14]);
            #1;
            check({tag, " allow"}, {15'd0, wr_allow}, {15'd0, v[7]});
            check({tag, " rd_valid"}, {15'd0, rd_valid}, {15'd0, v[6]});
            if (v[6]) begin
                check({tag, " rd_data"}, rd_data, {10'd0, v[5:0]});
            end
        end

        // R1 reset releases the seal and restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cand_addr = 6'd63;
        #1;
        check("R1 allow after reset", {15'd0, wr_allow}, 16'd1);
        issue(1'b1, 1'b0, 2'b10, 6'd0);
        #1;
        check("R1 fetch after reset", rd_data, 16'd0);
        // R3 load works again after reset
        issue(1'b1, 1'b1, 2'b00, 6'h30);
        issue(1'b1, 1'b1, 2'b01, 6'd8);
        cand_addr = 6'd8;
        #1;
        check("R3 boundary 8 blocks 8", {15'd0, wr_allow}, 16'd0);
        cand_addr = 6'd7;
        #1;
        check("R2 address 7 allowed", {15'd0, wr_allow}, 16'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule